// File: doc/BRIEF.md
# Serial Control Port with Mode Register Bank

This block is the control port of a multichannel audio converter. An external host talks to it over a four-wire serial link (active-low select, serial clock, data in, data out). Each access is one fixed 16-bit frame. The frame names one of sixteen addresses and says whether the access is a read or a write. On a write, the frame carries ten bits of data for a mode register. On a read, the block returns the contents of the named register inside the same frame.

The bank holds thirteen writable 10-bit mode registers and two read-only 6-bit peak-status registers. The mode registers drive a single flat parallel bus to the converter datapath. The status values come from outside the block, from the peak detectors. When a read of a status register completes, the block pulses a strobe for one clock so that the detector that owns the value can clear itself.

The serial pins are brought into the system clock through two-flop synchronisers, and all serial edges are detected in that domain. The serial clock must therefore run well below the system clock.

Top module: `spi_ctl_regfile`

## Requirements
- R1: A frame is sampled MSB first on rising serial-clock edges while `spi_cs_n` is low. Frame bit 15..12 is the address, bit 11 is the direction (1 = read, 0 = write), bit 10 is reserved, and bits 9..0 are data.
- R2: A write frame to a mode address (0..9 or 12..14) stores its data bits. Mode address a appears on `cfg_o[10*i +: 10]`, where i = a for a < 10 and i = a - 2 for a >= 12. The new value is visible within 8 system clocks after `spi_cs_n` rises.
- R3: A frame takes effect only when `spi_cs_n` rises after exactly 16 serial-clock rising edges. A frame with fewer or more edges changes no register and produces no strobe.
- R4: A frame whose reserved bit is 1 is discarded. It causes no register write and no strobe, and on a read it returns all zeros on `spi_miso`.
- R5: Writes to the status addresses 10 and 11 and to the unused address 15 are ignored. No mode register changes.
- R6: On a read frame of a mode register, `spi_miso` presents the 10-bit contents MSB first. The bits are valid for sampling at rising serial-clock edges 7 through 16 of the frame.
- R7: A read of address 10 returns `stat_i[5:0]`, and a read of address 11 returns `stat_i[11:6]`. In both cases the status occupies data bits 9..4 and bits 3..0 are zero.
- R8: A read of address 15 returns all zeros.
- R9: Each completed valid read of address 10 or 11 pulses `rd_stb_o[0]` or `rd_stb_o[1]` respectively, for exactly one system clock. Reads of other addresses and dropped frames produce no pulse.
- R10: While `rst` is high, all mode registers clear to zero, and `spi_miso` and `rd_stb_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Frame select, active low |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial read data to the host |
| stat_i | input | 12 | Two 6-bit peak-status values, address 10 in bits 5..0 |
| cfg_o | output | 130 | Thirteen 10-bit mode registers, flattened |
| rd_stb_o | output | 2 | One-clock pulse when a status register has been read |

## Verification
The hardest situations to reach are frames that look valid but must leave no trace. These include a frame that stops one edge short, one that runs one edge long, and one that sets the reserved bit. In each case the bit pattern is otherwise a legal write or a legal status read. The driver task therefore takes the number of serial edges as an argument and builds these frames out of normal traffic. After each one, the mode bus is compared with the model, and a status register is read back to show that no strobe fired and no register changed. Read data is captured bit by bit at the host-side sampling edge and compared against a queue of expected words.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int FRAME_W    = 16;
  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 10;
  localparam int STAT_W     = 6;
  localparam int NUM_STAT   = 2;
  localparam int STAT_ADDR0 = 10;
  localparam int NUM_MODE   = 13;
  localparam int HDR_BITS   = FRAME_W - DATA_W;
  localparam int CNT_W      = $clog2(2 * FRAME_W);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              rd;
    logic              rsv;
    logic [DATA_W-1:0] data;
  } frame_t;

  function automatic logic [ADDR_W-1:0] mode_addr(input int idx);
    int a;
    a = (idx < STAT_ADDR0) ? idx : idx + NUM_STAT;
    return a[ADDR_W-1:0];
  endfunction
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/ctl_shifter.sv
module ctl_shifter
  import spi_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              mosi,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] hdr_addr,
  output logic              frm_vld,
  output frame_t            frm,
  output logic              miso
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_BITS - 1);

  logic               sclk_d, cs_d;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] sh;
  logic [DATA_W-1:0]  tx;
  logic               hdr_vld;
  logic               sclk_rise, cs_fall, cs_rise;
  logic               hdr_rd, hdr_rsv;

  assign sclk_rise = sclk & ~sclk_d;
  assign cs_fall   = ~cs_n & cs_d;
  assign cs_rise   = cs_n & ~cs_d;

  // header fields sit at the bottom of the shifter once six bits are in
  assign hdr_addr = sh[HDR_BITS-1 -: ADDR_W];
  assign hdr_rd   = sh[1];
  assign hdr_rsv  = sh[0];
  assign frm      = frame_t'(sh);
  assign miso     = tx[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d  <= 1'b0;
      cs_d    <= 1'b1;
      cnt     <= '0;
      sh      <= '0;
      tx      <= '0;
      hdr_vld <= 1'b0;
      frm_vld <= 1'b0;
    end else begin
      sclk_d  <= sclk;
      cs_d    <= cs_n;
      hdr_vld <= 1'b0;
      frm_vld <= 1'b0;
      if (cs_fall) begin
        cnt <= '0;
        tx  <= '0;
      end else if (hdr_vld) begin
        tx <= (hdr_rd && !hdr_rsv) ? rd_word : '0;
      end else if (!cs_n && sclk_rise) begin
        sh <= {sh[FRAME_W-2:0], mosi};
        tx <= {tx[DATA_W-2:0], 1'b0};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        if (cnt == CNT_HDR) hdr_vld <= 1'b1;
      end else if (cs_rise) begin
        tx <= '0;
        if (cnt == CNT_FULL) frm_vld <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ctl_bank.sv
module ctl_bank
  import spi_ctl_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       frm_vld,
  input  frame_t                     frm,
  input  logic [ADDR_W-1:0]          hdr_addr,
  input  logic [NUM_STAT*STAT_W-1:0] stat_i,
  output logic [NUM_MODE*DATA_W-1:0] cfg_o,
  output logic [DATA_W-1:0]          rd_word,
  output logic [NUM_STAT-1:0]        rd_stb_o
);
  localparam int PAD_W = DATA_W - STAT_W;

  logic wr_ok, rd_ok;
  logic [DATA_W-1:0] mode_rd [NUM_MODE];
  logic [DATA_W-1:0] stat_rd [NUM_STAT];

  assign wr_ok = frm_vld && !frm.rd && !frm.rsv;
  assign rd_ok = frm_vld &&  frm.rd && !frm.rsv;

  for (genvar g = 0; g < NUM_MODE; g++) begin : g_mode
    localparam logic [ADDR_W-1:0] A = mode_addr(g);
    always_ff @(posedge clk) begin
      if (rst) cfg_o[g*DATA_W +: DATA_W] <= '0;
      else if (wr_ok && frm.addr == A) cfg_o[g*DATA_W +: DATA_W] <= frm.data;
    end
    assign mode_rd[g] = (hdr_addr == A) ? cfg_o[g*DATA_W +: DATA_W] : '0;
  end

  for (genvar k = 0; k < NUM_STAT; k++) begin : g_stat
    localparam logic [ADDR_W-1:0] A = ADDR_W'(STAT_ADDR0 + k);
    always_ff @(posedge clk) begin
      if (rst) rd_stb_o[k] <= 1'b0;
      else     rd_stb_o[k] <= rd_ok && frm.addr == A;
    end
    assign stat_rd[k] = (hdr_addr == A) ? {stat_i[k*STAT_W +: STAT_W], {PAD_W{1'b0}}} : '0;
  end

  // unmatched addresses (15) contribute nothing, so they read as zero
  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_MODE; i++) rd_word = rd_word | mode_rd[i];
    for (int k = 0; k < NUM_STAT; k++) rd_word = rd_word | stat_rd[k];
  end
endmodule

// File: rtl/spi_ctl_regfile.sv
module spi_ctl_regfile
  import spi_ctl_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       spi_cs_n,
  input  logic                       spi_sclk,
  input  logic                       spi_mosi,
  output logic                       spi_miso,
  input  logic [NUM_STAT*STAT_W-1:0] stat_i,
  output logic [NUM_MODE*DATA_W-1:0] cfg_o,
  output logic [NUM_STAT-1:0]        rd_stb_o
);
  logic [2:0]        pins_s;
  logic [ADDR_W-1:0] hdr_addr;
  logic [DATA_W-1:0] rd_word;
  logic              frm_vld;
  frame_t            frm;

  ctl_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_cs_n, spi_sclk, spi_mosi}),
    .q   (pins_s)
  );

  ctl_shifter u_shift (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (pins_s[2]),
    .sclk     (pins_s[1]),
    .mosi     (pins_s[0]),
    .rd_word  (rd_word),
    .hdr_addr (hdr_addr),
    .frm_vld  (frm_vld),
    .frm      (frm),
    .miso     (spi_miso)
  );

  ctl_bank u_bank (
    .clk      (clk),
    .rst      (rst),
    .frm_vld  (frm_vld),
    .frm      (frm),
    .hdr_addr (hdr_addr),
    .stat_i   (stat_i),
    .cfg_o    (cfg_o),
    .rd_word  (rd_word),
    .rd_stb_o (rd_stb_o)
  );
endmodule

// File: rtl/spi_ctl_regfile_chk.sv
module spi_ctl_regfile_chk
  import spi_ctl_pkg::*;
(
  input logic                       clk,
  input logic                       rst,
  input logic                       frm_vld,
  input frame_t                     frm,
  input logic                       spi_miso,
  input logic [NUM_MODE*DATA_W-1:0] cfg_o,
  input logic [NUM_STAT-1:0]        rd_stb_o
);
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (cfg_o == '0 && rd_stb_o == '0 && !spi_miso));

  a_r3_cfg_needs_frame: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_o) |-> $past(frm_vld));

  a_r4_rsv_discard: assert property (@(posedge clk) disable iff (rst)
    (frm_vld && frm.rsv) |=> ($stable(cfg_o) && rd_stb_o == '0));

  a_r5_ro_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (frm_vld && !frm.rd && (frm.addr == 4'd10 || frm.addr == 4'd11 || frm.addr == 4'd15))
    |=> $stable(cfg_o));

  a_r9_stb_needs_read: assert property (@(posedge clk) disable iff (rst)
    (rd_stb_o != '0) |-> ($past(frm_vld) && $past(frm.rd)));

  a_r9_stb_single: assert property (@(posedge clk) disable iff (rst)
    (rd_stb_o != '0) |=> (rd_stb_o == '0));

  a_r9_stb_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_stb_o));
endmodule

bind spi_ctl_regfile spi_ctl_regfile_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .frm_vld  (frm_vld),
  .frm      (frm),
  .spi_miso (spi_miso),
  .cfg_o    (cfg_o),
  .rd_stb_o (rd_stb_o)
);

// File: tb/tb_spi_ctl_regfile.sv
module tb_spi_ctl_regfile;
  localparam int CLK_T = 10;
  localparam int HALF  = 6;
  localparam int WD    = 150000;

  logic clk = 0, rst = 1;
  logic spi_cs_n = 1, spi_sclk = 0, spi_mosi = 0;
  logic spi_miso;
  logic [11:0]  stat_i = {6'h15, 6'h2B};
  logic [129:0] cfg_o;
  logic [1:0]   rd_stb_o;

  int total = 0, bad = 0, cyc = 0;
  int stb_cnt0 = 0, stb_cnt1 = 0;
  logic [9:0] mdl [16];
  logic [9:0] expq [$];
  string      reqq [$];
  logic [15:0] cap;
  int          capn;
  logic        armed = 0;

  spi_ctl_regfile dut (.*);

  always #(CLK_T/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<%0d", cyc, WD);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rd_stb_o[0]) stb_cnt0++;
    if (rd_stb_o[1]) stb_cnt1++;
  end

  // monitor: capture host-side samples and compare on frame end
  always @(negedge spi_cs_n) begin cap = '0; capn = 0; end
  always @(posedge spi_sclk) if (!spi_cs_n) begin cap = {cap[14:0], spi_miso}; capn++; end
  always @(posedge spi_cs_n) begin
    if (armed) begin
      string r;
      logic [9:0] e;
      e = expq.pop_front();
      r = reqq.pop_front();
      check(r, {22'd0, cap[9:0]}, {22'd0, e});
      armed = 0;
    end
  end

  function automatic int slot(int a);
    return (a < 10) ? a : a - 2;
  endfunction

  task automatic frame(logic [15:0] w, int nbits);
    @(negedge clk); spi_cs_n = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = (i < 16) ? w[15-i] : 1'b0;
      repeat (HALF) @(negedge clk); spi_sclk = 1;
      repeat (HALF) @(negedge clk); spi_sclk = 0;
    end
    repeat (4) @(negedge clk); spi_cs_n = 1;
    repeat (12) @(negedge clk);
  endtask

  task automatic wr(int a, logic [9:0] d);
    frame({a[3:0], 2'b00, d}, 16);
    if (a != 10 && a != 11 && a != 15) mdl[a] = d;
  endtask

  task automatic rd(int a, string req);
    logic [9:0] e;
    if (a == 10) e = {stat_i[5:0], 4'b0};
    else if (a == 11) e = {stat_i[11:6], 4'b0};
    else if (a == 15) e = '0;
    else e = mdl[a];
    expq.push_back(e); reqq.push_back(req);
    armed = 1;
    frame({a[3:0], 2'b10, 10'h000}, 16);
  endtask

  task automatic chk_cfg(string req);
    for (int a = 0; a < 15; a++)
      if (a != 10 && a != 11)
        check(req, {22'd0, cfg_o[slot(a)*10 +: 10]}, {22'd0, mdl[a]});
  endtask

  initial begin
    for (int a = 0; a < 16; a++) mdl[a] = '0;
    repeat (5) @(negedge clk);
    check("R10 cfg", {2'd0, cfg_o[129:100]}, 32'd0);
    check("R10 cfg_lo", cfg_o[31:0], 32'd0);
    check("R10 miso", {31'd0, spi_miso}, 32'd0);
    check("R10 stb", {30'd0, rd_stb_o}, 32'd0);
    rst = 0;
    repeat (5) @(negedge clk);

    // R1 R2: writes with varied data patterns, all mode addresses
    for (int a = 0; a < 15; a++)
      if (a != 10 && a != 11) wr(a, 10'(a * 73 + 10'h155));
    wr(0, 10'h3FF); wr(14, 10'h201); wr(5, 10'h000);
    chk_cfg("R2 write");

    // R6: readback of mode registers
    rd(0, "R6 read0"); rd(14, "R6 read14"); rd(7, "R6 read7"); rd(5, "R6 read5");

    // R5: writes to read-only and unused addresses
    wr(10, 10'h3FF); wr(11, 10'h155); wr(15, 10'h2AA);
    chk_cfg("R5 ro write");

    // R7 R9: status reads and strobes
    rd(10, "R7 stat0"); rd(11, "R7 stat1");
    check("R9 stb0", stb_cnt0, 1);
    check("R9 stb1", stb_cnt1, 1);
    rd(3, "R6 read3");
    check("R9 no stb mode", stb_cnt0 + stb_cnt1, 2);

    // R8: unused address reads zero
    rd(15, "R8 addr15");

    // R4: reserved bit set on write and on status read
    frame({4'd2, 2'b01, 10'h0F0}, 16);
    chk_cfg("R4 rsv write");
    expq.push_back('0); reqq.push_back("R4 rsv read"); armed = 1;
    frame({4'd10, 2'b11, 10'h000}, 16);
    check("R4 rsv no stb", stb_cnt0, 1);

    // R3: short and long frames
    frame({4'd3, 2'b00, 10'h0AA}, 15);
    frame({4'd3, 2'b00, 10'h0AA}, 17);
    chk_cfg("R3 bad count write");
    frame({4'd11, 2'b10, 10'h000}, 15);
    frame({4'd11, 2'b10, 10'h000}, 17);
    check("R3 bad count no stb", stb_cnt1, 1);
    rd(3, "R3 reg intact");

    // status change reflected on next read
    stat_i = {6'h3F, 6'h01};
    rd(10, "R7 stat0 new"); rd(11, "R7 stat1 new");
    check("R9 stb totals", stb_cnt0 + stb_cnt1, 4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule